// File: doc/BRIEF.md
# Status Register and Write-Protection Gate

This block keeps the one-byte status register of a small serial nonvolatile memory and decides, cycle by cycle, whether an array write or a status write may start. A serial front end outside the block decodes commands and hands over one-cycle strobes: arm and disarm of the write latch, set and clear of a user flag, a status-write request with its data byte, and an array-write request with its target address. The block also watches the hardware protect input and the busy line of the write engine.

A cycle-tracking state machine has three states. `CYC_IDLE` means no write is in flight. `CYC_ARRAY` follows an accepted array write. `CYC_STATUS` follows an accepted status write, and the new protection fields are held in a pending register. The transitions are as follows. IDLE goes to STATUS on an accepted status request; this has priority over an array request. IDLE goes to ARRAY on an accepted array request. ARRAY or STATUS goes back to IDLE on a busy falling edge, and the exit from STATUS commits the pending fields. Because the commit happens at the end of the cycle, a change on the protect input during the cycle cannot cancel it.

The protection fields are the lock-enable bit and the two range-select bits. They stand in for nonvolatile bits, so they reset to parameter values. The write latch and the user flag are volatile and reset to zero.

Top module: `wprot_status_unit`

## Requirements
- R1: After reset the status byte is 0x00 with default parameters, and both permission outputs are low.
- R2: Status byte layout: bit 7 lock-enable, bit 6 user flag, bits 5 and 4 always 0, bits 3:2 range select, bit 1 write latch, bit 0 a combinational copy of the busy input.
- R3: An arm strobe sets the write latch at the next clock edge and a disarm strobe clears it. When both come in the same cycle, the latch is cleared.
- R4: `arr_wr_ok` is high only when all of these hold: the latch is set, the state is idle, busy is low now and was low in the previous cycle, and the address lies outside the selected range.
- R5: The range select (11-bit address) works as follows: 00 protects nothing; 01 protects the top quarter 0x600–0x7FF; 10 protects the top half 0x400–0x7FF; 11 protects every address.
- R6: `stat_wr_ok` is high only when the latch is set and the same idle conditions as R4 hold. It is also low while lock-enable is 1 and `hw_protect_n` is low. With `hw_protect_n` high, lock-enable has no effect.
- R7: An accepted status write loads data bits 7, 6 and 3:2 into lock-enable, flag and range select at the busy falling edge that ends the cycle. Data bits 5, 4, 1 and 0 are ignored. Driving `hw_protect_n` low during the cycle does not cancel the write.
- R8: Once lock-enable is 1 and `hw_protect_n` is low, later status writes are refused.
- R9: Every busy falling edge clears the write latch, and this has priority over an arm in the same cycle.
- R10: A flag-set strobe sets the flag and a flag-clear strobe clears it; clear wins when both come together. A flag strobe in the same cycle as a status commit overrides the committed flag value.
- R11: A request made while its permission output is low changes nothing: the status byte keeps its value and the state stays idle.
- R12: After a request is accepted, both permission outputs stay low until the write cycle ends with a busy falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_arm | input | 1 | Set write latch strobe |
| cmd_disarm | input | 1 | Clear write latch strobe |
| cmd_flag_set | input | 1 | Set user flag strobe |
| cmd_flag_clr | input | 1 | Clear user flag strobe |
| stat_wr_req | input | 1 | Status write request strobe |
| stat_wr_data | input | 8 | Data byte of the status write |
| arr_wr_req | input | 1 | Array write request strobe |
| arr_addr | input | AW (11) | Target array address |
| hw_protect_n | input | 1 | Hardware protect level, low asserts protection |
| busy | input | 1 | Write engine busy |
| status_byte | output | 8 | Status register contents |
| arr_wr_ok | output | 1 | Array write allowed at `arr_addr` |
| stat_wr_ok | output | 1 | Status write allowed |

## Verification
The end of a status-write cycle, marked by the busy falling edge, can fall in the same cycle as flag strobes and an arm strobe. The bench drives busy low together with a flag-clear and an arm on the same edge that commits a pending byte whose flag bit is 1. It then judges that the committed range field appears, the flag reads 0, and the latch reads 0. The bench also drops the protect input inside a status cycle that sets lock-enable, and checks that the commit still happens and that the next request is refused.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ARRAY  = 2'd1,
        CYC_STATUS = 2'd2
    } cyc_state_t;

    localparam int BIT_LOCK   = 7;
    localparam int BIT_FLAG   = 6;
    localparam int BIT_SEL_HI = 3;
    localparam int BIT_SEL_LO = 2;
    localparam int BIT_ARM    = 1;
    localparam int BIT_BUSY   = 0;
endpackage

// File: rtl/sreg_range_guard.sv
module sreg_range_guard #(
    parameter int AW = 11
) (
    input  logic [1:0]    sel,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int TOP = AW - 1;

    always_comb begin
        unique case (sel)
            2'b00:   hit = 1'b0;
            2'b01:   hit = addr[TOP] & addr[TOP-1];
            2'b10:   hit = addr[TOP];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sreg_latch_ctrl.sv
module sreg_latch_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic flag_set,
    input  logic flag_clr,
    input  logic cyc_end,
    input  logic commit,
    input  logic commit_flag,
    output logic arm_q,
    output logic flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (cyc_end || disarm)
                arm_q <= 1'b0;
            else if (arm)
                arm_q <= 1'b1;

            if (flag_clr)
                flag_q <= 1'b0;
            else if (flag_set)
                flag_q <= 1'b1;
            else if (commit)
                flag_q <= commit_flag;
        end
    end
endmodule

// File: rtl/sreg_cycle_fsm.sv
module sreg_cycle_fsm
    import sreg_pkg::*;
#(
    parameter logic       INIT_LOCK = 1'b0,
    parameter logic [1:0] INIT_SEL  = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arr_go,
    input  logic       stat_go,
    input  logic [7:0] wdata,
    input  logic       cyc_end,
    output cyc_state_t state,
    output logic       lock_q,
    output logic [1:0] sel_q,
    output logic       commit,
    output logic       commit_flag
);
    cyc_state_t state_nx;
    logic       pend_lock;
    logic       pend_flag;
    logic [1:0] pend_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CYC_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CYC_IDLE: begin
                if (stat_go)
                    state_nx = CYC_STATUS;
                else if (arr_go)
                    state_nx = CYC_ARRAY;
            end
            CYC_ARRAY, CYC_STATUS: begin
                if (cyc_end)
                    state_nx = CYC_IDLE;
            end
            default: state_nx = CYC_IDLE;
        endcase
    end

    always_comb begin
        commit      = (state == CYC_STATUS) && cyc_end;
        commit_flag = pend_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_lock <= 1'b0;
            pend_flag <= 1'b0;
            pend_sel  <= 2'b00;
            lock_q    <= INIT_LOCK;
            sel_q     <= INIT_SEL;
        end else begin
            if (stat_go && state == CYC_IDLE) begin
                pend_lock <= wdata[BIT_LOCK];
                pend_flag <= wdata[BIT_FLAG];
                pend_sel  <= wdata[BIT_SEL_HI:BIT_SEL_LO];
            end
            if (commit) begin
                lock_q <= pend_lock;
                sel_q  <= pend_sel;
            end
        end
    end
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
    import sreg_pkg::*;
#(
    parameter int         AW        = 11,
    parameter logic       INIT_LOCK = 1'b0,
    parameter logic [1:0] INIT_SEL  = 2'b00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_arm,
    input  logic          cmd_disarm,
    input  logic          cmd_flag_set,
    input  logic          cmd_flag_clr,
    input  logic          stat_wr_req,
    input  logic [7:0]    stat_wr_data,
    input  logic          arr_wr_req,
    input  logic [AW-1:0] arr_addr,
    input  logic          hw_protect_n,
    input  logic          busy,
    output logic [7:0]    status_byte,
    output logic          arr_wr_ok,
    output logic          stat_wr_ok
);
    cyc_state_t state;
    logic       busy_q;
    logic       cyc_end;
    logic       ready;
    logic       arm_q;
    logic       flag_q;
    logic       lock_q;
    logic [1:0] sel_q;
    logic       commit;
    logic       commit_flag;
    logic       range_hit;
    logic       arr_go;
    logic       stat_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else
            busy_q <= busy;
    end

    assign cyc_end = busy_q & ~busy;
    assign ready   = (state == CYC_IDLE) & ~busy & ~busy_q;

    sreg_range_guard #(.AW(AW)) u_guard (
        .sel  (sel_q),
        .addr (arr_addr),
        .hit  (range_hit)
    );

    always_comb begin
        arr_wr_ok  = arm_q & ready & ~range_hit;
        stat_wr_ok = arm_q & ready & ~(lock_q & ~hw_protect_n);
        arr_go     = arr_wr_req & arr_wr_ok;
        stat_go    = stat_wr_req & stat_wr_ok;
    end

    sreg_cycle_fsm #(.INIT_LOCK(INIT_LOCK), .INIT_SEL(INIT_SEL)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arr_go      (arr_go),
        .stat_go     (stat_go),
        .wdata       (stat_wr_data),
        .cyc_end     (cyc_end),
        .state       (state),
        .lock_q      (lock_q),
        .sel_q       (sel_q),
        .commit      (commit),
        .commit_flag (commit_flag)
    );

    sreg_latch_ctrl u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (cmd_arm),
        .disarm      (cmd_disarm),
        .flag_set    (cmd_flag_set),
        .flag_clr    (cmd_flag_clr),
        .cyc_end     (cyc_end),
        .commit      (commit),
        .commit_flag (commit_flag),
        .arm_q       (arm_q),
        .flag_q      (flag_q)
    );

    always_comb begin
        status_byte                        = 8'h00;
        status_byte[BIT_LOCK]              = lock_q;
        status_byte[BIT_FLAG]              = flag_q;
        status_byte[BIT_SEL_HI:BIT_SEL_LO] = sel_q;
        status_byte[BIT_ARM]               = arm_q;
        status_byte[BIT_BUSY]              = busy;
    end
endmodule

// File: rtl/sreg_status_chk.sv
module sreg_status_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_disarm,
    input logic          cmd_flag_clr,
    input logic [AW-1:0] arr_addr,
    input logic          hw_protect_n,
    input logic          busy,
    input logic [7:0]    status_byte,
    input logic          arr_wr_ok,
    input logic          stat_wr_ok
);
    logic addr_in_range;
    always_comb begin
        case (status_byte[3:2])
            2'b00:   addr_in_range = 1'b0;
            2'b01:   addr_in_range = arr_addr[AW-1] & arr_addr[AW-2];
            2'b10:   addr_in_range = arr_addr[AW-1];
            default: addr_in_range = 1'b1;
        endcase
    end

    // R2
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[5:4] == 2'b00);
    // R2
    busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[0] == busy);
    // R3
    disarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disarm |=> !status_byte[1]);
    // R9
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !status_byte[1]);
    // R5
    range_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok |-> !addr_in_range);
    // R6
    lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !hw_protect_n) |-> !stat_wr_ok);
    // R4
    latch_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_ok || stat_wr_ok) |-> status_byte[1]);
    // R12
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!arr_wr_ok && !stat_wr_ok));
    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flag_clr |=> !status_byte[6]);
endmodule

bind wprot_status_unit sreg_status_chk #(.AW(AW)) u_status_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_disarm   (cmd_disarm),
    .cmd_flag_clr (cmd_flag_clr),
    .arr_addr     (arr_addr),
    .hw_protect_n (hw_protect_n),
    .busy         (busy),
    .status_byte  (status_byte),
    .arr_wr_ok    (arr_wr_ok),
    .stat_wr_ok   (stat_wr_ok)
);

// File: tb/wprot_status_unit_bench.sv
`timescale 1ns/1ps
module wprot_status_unit_bench;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_arm = 1'b0, cmd_disarm = 1'b0;
    logic          cmd_flag_set = 1'b0, cmd_flag_clr = 1'b0;
    logic          stat_wr_req = 1'b0;
    logic [7:0]    stat_wr_data = 8'h00;
    logic          arr_wr_req = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic          hw_protect_n = 1'b1;
    logic          busy = 1'b0;
    logic [7:0]    status_byte;
    logic          arr_wr_ok, stat_wr_ok;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    wprot_status_unit #(.AW(AW)) u_wprot_status_unit (
        .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm),
        .cmd_flag_set(cmd_flag_set), .cmd_flag_clr(cmd_flag_clr),
        .stat_wr_req(stat_wr_req), .stat_wr_data(stat_wr_data),
        .arr_wr_req(arr_wr_req), .arr_addr(arr_addr),
        .hw_protect_n(hw_protect_n), .busy(busy),
        .status_byte(status_byte), .arr_wr_ok(arr_wr_ok), .stat_wr_ok(stat_wr_ok)
    );

    // {range select, address, expected arr_wr_ok}
    localparam logic [13:0] RANGE_TBL [9] = '{
        {2'b00, 11'h7FF, 1'b1}, {2'b00, 11'h000, 1'b1},
        {2'b01, 11'h5FF, 1'b1}, {2'b01, 11'h600, 1'b0}, {2'b01, 11'h7FF, 1'b0},
        {2'b10, 11'h3FF, 1'b1}, {2'b10, 11'h400, 1'b0},
        {2'b11, 11'h000, 1'b0}, {2'b11, 11'h7FF, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic arm();
        cmd_arm = 1'b1; step(); cmd_arm = 1'b0;
    endtask

    task automatic prog(input logic [7:0] data, input logic drop_pin);
        arm();
        stat_wr_req = 1'b1; stat_wr_data = data; step();
        stat_wr_req = 1'b0;
        busy = 1'b1;
        if (drop_pin) hw_protect_n = 1'b0;
        step(); step();
        busy = 1'b0; step();
    endtask

    initial begin
        logic [1:0] cur_sel;
        repeat (3) step();
        rst_n = 1'b1; step();
        #1;
        chk("R1 reset status", status_byte, 8'h00);
        chk("R1 reset perms", {arr_wr_ok, stat_wr_ok}, 2'b00);

        arm();
        chk("R3 arm sets latch", status_byte, 8'h02);
        cmd_arm = 1'b1; cmd_disarm = 1'b1; step(); cmd_arm = 1'b0; cmd_disarm = 1'b0;
        chk("R3 disarm wins", status_byte, 8'h00);
        #1 chk("R4 no latch no write", arr_wr_ok, 1'b0);

        cur_sel = 2'b00;
        for (int i = 0; i < 9; i++) begin
            if (RANGE_TBL[i][13:12] != cur_sel) begin
                prog({4'b0000, RANGE_TBL[i][13:12], 2'b00}, 1'b0);
                cur_sel = RANGE_TBL[i][13:12];
                chk("R7 select committed", status_byte, {4'b0000, cur_sel, 2'b00});
            end
            arm();
            arr_addr = RANGE_TBL[i][11:1];
            #1 chk($sformatf("R5 range entry %0d", i), arr_wr_ok, RANGE_TBL[i][0]);
        end

        // R7: lock committed even though pin drops mid-cycle
        prog(8'h80, 1'b1);
        chk("R7 lock commit despite pin", status_byte, 8'h80);
        arm();
        #1 chk("R8 locked refuses", stat_wr_ok, 1'b0);
        stat_wr_req = 1'b1; stat_wr_data = 8'h0C; step(); stat_wr_req = 1'b0; step();
        chk("R11 refused write no change", status_byte, 8'h82);
        hw_protect_n = 1'b1;
        #1 chk("R6 pin high allows", stat_wr_ok, 1'b1);
        prog(8'h00, 1'b0);
        chk("R6 unlock commit", status_byte, 8'h00);

        // R12 / R9 array flow
        arm();
        arr_addr = 11'h100; arr_wr_req = 1'b1;
        #1 chk("R4 array allowed", arr_wr_ok, 1'b1);
        step(); arr_wr_req = 1'b0;
        #1 chk("R12 pending blocks", arr_wr_ok, 1'b0);
        busy = 1'b1; step();
        chk("R2 busy bit", status_byte, 8'h03);
        busy = 1'b0; step();
        chk("R9 fall clears latch", status_byte, 8'h00);
        arm();
        #1 chk("R12 idle again", arr_wr_ok, 1'b1);

        // R7 ignored bits
        prog(8'h7F, 1'b0);
        chk("R7 ignored data bits", status_byte, 8'h4C);
        prog(8'h04, 1'b0);
        chk("R7 rewrite", status_byte, 8'h04);

        // R11 refused array write
        arm();
        arr_addr = 11'h700; arr_wr_req = 1'b1;
        #1 chk("R5 top quarter blocked", arr_wr_ok, 1'b0);
        step(); arr_wr_req = 1'b0; arr_addr = 11'h100;
        #1 chk("R11 still idle", arr_wr_ok, 1'b1);
        chk("R11 status kept", status_byte, 8'h06);

        // R10 flag
        cmd_flag_set = 1'b1; step(); cmd_flag_set = 1'b0;
        chk("R10 flag set", status_byte, 8'h46);
        cmd_flag_set = 1'b1; cmd_flag_clr = 1'b1; step();
        cmd_flag_set = 1'b0; cmd_flag_clr = 1'b0;
        chk("R10 clear wins", status_byte, 8'h06);

        // same cycle: commit + flag clear + arm
        stat_wr_req = 1'b1; stat_wr_data = 8'h48; step(); stat_wr_req = 1'b0;
        busy = 1'b1; step(); step();
        busy = 1'b0; cmd_flag_clr = 1'b1; cmd_arm = 1'b1; step();
        cmd_flag_clr = 1'b0; cmd_arm = 1'b0;
        chk("R10 R9 same cycle commit", status_byte, 8'h08);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule